// File: doc/BRIEF.md
# Four-Wide Register Rename Map

This block is the rename stage of a four-wide out-of-order core with 32 architectural registers. Each cycle it takes a group of up to four decoded instructions, each with two source register numbers and an optional destination. For every source it reports one of two results. Either the value already sits in the architectural register file, or it has not been produced yet. In the second case the block gives the tag of the in-flight instruction that will produce it. Each destination receives a fresh tag from a pool of 32. The mapping for that register then points at the new tag. Write-after-read and write-after-write hazards therefore disappear, and only true read-after-write dependencies reach the scheduler.

Because four instructions are renamed together, a source may name a register that an older instruction in the same group writes. That source must receive the older instruction's new tag instead of the stale table entry, so the block bypasses tags across the group. When an instruction commits, in program order, its tag returns to the pool. The mapping for its register falls back to the register file, unless a newer producer has taken that register since. A flush input discards all speculative state in one cycle.

Source results and destination tags are combinational outputs of the current group and the stored state. Table and pool updates become visible from the next cycle.

Top module: `rename_alias_table`

## Requirements
- R1: A group of up to four lanes is accepted in a cycle in which `grp_ready` is high. Its source results and destination tags are valid in that same cycle, and its table and pool updates are visible from the next cycle.
- R2: A valid source that no older lane of the group writes returns the stored entry for its register. `busy`=0 means "read the register file"; `busy`=1 together with a tag means "wait for that producer".
- R3: A valid source whose register is written by an older renamed lane of the same group returns `busy`=1 and the tag of the youngest such older lane. A lane's own destination and invalid lanes never feed its sources.
- R4: A lane is renamed when its valid bit, its destination enable and a nonzero destination register are all set. It receives a tag that was free and that differs from every other tag in the group. Free tags are handed out lowest number first, to the lowest-numbered renamed lane first.
- R5: When several lanes of one group write the same register, the table keeps only the tag of the highest-numbered such lane.
- R6: Register 0 is never renamed. A source naming it always returns `busy`=0, and a destination naming it takes no tag and leaves the table unchanged.
- R7: When fewer tags are free than lanes to rename, `grp_ready` is low and neither the table nor the pool changes for that group.
- R8: A commit returns `cmt_tag` to the pool from the next cycle. It reverts the entry of `cmt_reg` to the register file only when that entry is busy and holds `cmt_tag`. Otherwise the entry stays unchanged.
- R9: When a commit and a renamed destination name the same register in the same cycle, the new rename wins.
- R10: While `flush` is high, `grp_ready` is low. From the next cycle every entry reads as the register file and all 32 tags are free, whatever commit came in the flush cycle.
- R11: After synchronous reset the block is in the same state as after a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 4 | Lane carries an instruction |
| src_a_reg | input | 4x5 | First source register per lane |
| src_b_reg | input | 4x5 | Second source register per lane |
| dst_en | input | 4 | Lane writes a destination |
| dst_reg | input | 4x5 | Destination register per lane |
| grp_ready | output | 1 | Group is renamed this cycle |
| src_a_busy | output | 4 | First source waits on a producer |
| src_a_tag | output | 4x5 | Producer tag of the first source |
| src_b_busy | output | 4 | Second source waits on a producer |
| src_b_tag | output | 4x5 | Producer tag of the second source |
| dst_tag | output | 4x5 | Tag given to each renamed destination |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_reg | input | 5 | Destination register of the committing instruction |
| cmt_tag | input | 5 | Tag of the committing instruction |
| flush | input | 1 | Discard all speculative mappings and tags |

## Verification
Every source result, destination tag and `grp_ready` depends combinationally on the current inputs and the stored state. The bench therefore drives each group on the falling edge and samples the outputs two nanoseconds later, still inside that cycle. Commits, renames and flushes affect lookups only from the following cycle. The bench's reference table and pool are updated just after the rising edge, and the next group is judged against them. Ignored commits and stalled groups are observed through a lookup group issued in the cycle that follows.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int LANES  = 4;
    localparam int AREGS  = 32;
    localparam int TAGS   = 32;
    localparam int AREG_W = $clog2(AREGS);
    localparam int TAG_W  = $clog2(TAGS);

    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // One mapping: busy=0 -> value in register file, busy=1 -> wait for tag
    typedef struct packed {
        logic busy;
        tag_t tag;
    } map_ent_t;

    // Lane takes a new tag only if valid, enabled and not register 0
    function automatic logic lane_renames(input logic vld, input logic en, input areg_t r);
        return vld && en && (r != '0);
    endfunction

    // Source lookup with bypass from older lanes of the same group
    function automatic map_ent_t resolve_src(
        input areg_t                src,
        input int                   lane,
        input map_ent_t             stored,
        input logic [LANES-1:0]     need,
        input areg_t [LANES-1:0]    dst,
        input tag_t  [LANES-1:0]    grant
    );
        map_ent_t res;
        res = stored;
        if (src == '0) begin
            res = '0;
        end else begin
            for (int j = 0; j < LANES; j++) begin
                if (j < lane && need[j] && dst[j] == src) begin
                    res.busy = 1'b1;
                    res.tag  = grant[j];
                end
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/rat_free_list.sv
module rat_free_list
    import rat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [LANES-1:0]      need,
    input  logic                  take,
    input  logic                  rel_valid,
    input  tag_t                  rel_tag,
    output tag_t [LANES-1:0]      grant,
    output logic                  enough,
    output logic [TAGS-1:0]       free_mask
);
    logic [TAGS-1:0] free_q;
    logic [TAGS-1:0] avail;
    logic [TAGS-1:0] taken;
    logic [TAGS-1:0] released;
    logic            found;

    // Lowest free tag to the lowest renaming lane, chained across lanes
    always_comb begin
        avail  = free_q;
        enough = 1'b1;
        found  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            grant[i] = '0;
            found    = 1'b0;
            if (need[i]) begin
                for (int t = 0; t < TAGS; t++) begin
                    if (!found && avail[t]) begin
                        grant[i] = tag_t'(t);
                        found    = 1'b1;
                    end
                end
                if (found) avail[grant[i]] = 1'b0;
                else       enough = 1'b0;
            end
        end
        taken = free_q & ~avail;
    end

    assign released  = rel_valid ? ({{(TAGS-1){1'b0}}, 1'b1} << rel_tag) : '0;
    assign free_mask = free_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            free_q <= '1;
        end else begin
            free_q <= (take ? (free_q & ~taken) : free_q) | released;
        end
    end
endmodule

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   write_en,
    input  logic [LANES-1:0]       need,
    input  areg_t [LANES-1:0]      dst,
    input  tag_t  [LANES-1:0]      grant,
    input  logic                   cmt_valid,
    input  areg_t                  cmt_reg,
    input  tag_t                   cmt_tag,
    output map_ent_t [AREGS-1:0]   ents
);
    map_ent_t [AREGS-1:0] ents_q;

    assign ents = ents_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ents_q <= '0;
        end else begin
            // Commit clears only a matching mapping
            for (int r = 0; r < AREGS; r++) begin
                if (cmt_valid && cmt_reg == areg_t'(r) &&
                    ents_q[r].busy && ents_q[r].tag == cmt_tag) begin
                    ents_q[r].busy <= 1'b0;
                end
            end
            // Renames follow; later lanes overwrite earlier ones
            if (write_en) begin
                for (int i = 0; i < LANES; i++) begin
                    if (need[i]) begin
                        ents_q[dst[i]] <= '{busy: 1'b1, tag: grant[i]};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
    import rat_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LANES-1:0]           grp_valid,
    input  logic [LANES-1:0][AREG_W-1:0] src_a_reg,
    input  logic [LANES-1:0][AREG_W-1:0] src_b_reg,
    input  logic [LANES-1:0]           dst_en,
    input  logic [LANES-1:0][AREG_W-1:0] dst_reg,
    output logic                       grp_ready,
    output logic [LANES-1:0]           src_a_busy,
    output logic [LANES-1:0][TAG_W-1:0] src_a_tag,
    output logic [LANES-1:0]           src_b_busy,
    output logic [LANES-1:0][TAG_W-1:0] src_b_tag,
    output logic [LANES-1:0][TAG_W-1:0] dst_tag,
    input  logic                       cmt_valid,
    input  logic [AREG_W-1:0]          cmt_reg,
    input  logic [TAG_W-1:0]           cmt_tag,
    input  logic                       flush
);
    logic [LANES-1:0]     need;
    tag_t [LANES-1:0]     grant;
    logic                 enough;
    logic [TAGS-1:0]      free_mask;
    map_ent_t [AREGS-1:0] ents;
    areg_t [LANES-1:0]    dst_r;

    assign grp_ready = enough && !flush;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            map_ent_t res_a;
            map_ent_t res_b;
            assign dst_r[i]      = areg_t'(dst_reg[i]);
            assign need[i]       = lane_renames(grp_valid[i], dst_en[i], dst_r[i]);
            assign res_a         = resolve_src(areg_t'(src_a_reg[i]), i, ents[src_a_reg[i]], need, dst_r, grant);
            assign res_b         = resolve_src(areg_t'(src_b_reg[i]), i, ents[src_b_reg[i]], need, dst_r, grant);
            assign src_a_busy[i] = res_a.busy;
            assign src_a_tag[i]  = res_a.tag;
            assign src_b_busy[i] = res_b.busy;
            assign src_b_tag[i]  = res_b.tag;
            assign dst_tag[i]    = grant[i];
        end
    endgenerate

    rat_free_list i_free (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .need      (need),
        .take      (grp_ready),
        .rel_valid (cmt_valid),
        .rel_tag   (tag_t'(cmt_tag)),
        .grant     (grant),
        .enough    (enough),
        .free_mask (free_mask)
    );

    rat_map_table i_map (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .write_en  (grp_ready),
        .need      (need),
        .dst       (dst_r),
        .grant     (grant),
        .cmt_valid (cmt_valid),
        .cmt_reg   (areg_t'(cmt_reg)),
        .cmt_tag   (tag_t'(cmt_tag)),
        .ents      (ents)
    );
endmodule

// File: rtl/rat_rename_checker.sv
module rat_rename_checker
    import rat_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         flush,
    input logic [LANES-1:0]             grp_valid,
    input logic [LANES-1:0][AREG_W-1:0] src_a_reg,
    input logic [LANES-1:0]             src_a_busy,
    input logic [LANES-1:0][TAG_W-1:0]  src_a_tag,
    input logic [LANES-1:0][AREG_W-1:0] dst_reg,
    input logic [LANES-1:0][TAG_W-1:0]  dst_tag,
    input logic [LANES-1:0]             need,
    input logic                         grp_ready,
    input logic                         cmt_valid,
    input logic [TAG_W-1:0]             cmt_tag,
    input logic [TAGS-1:0]              free_mask
);
    AST_ZERO_SRC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (grp_valid[2] && src_a_reg[2] == '0) |-> !src_a_busy[2]); // R6
    AST_GROUP_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (need[0] && grp_valid[1] && src_a_reg[1] == dst_reg[0])
        |-> (src_a_busy[1] && src_a_tag[1] == dst_tag[0])); // R3
    AST_TAGS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (grp_ready && need[0] && need[3]) |-> (dst_tag[0] != dst_tag[3])); // R4
    AST_TAGS_DISTINCT_MID: assert property (@(posedge clk) disable iff (rst)
        (grp_ready && need[1] && need[2]) |-> (dst_tag[1] != dst_tag[2])); // R4
    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
        (grp_ready && need[0]) |-> free_mask[dst_tag[0]]); // R4
    AST_STALL_HOLDS_POOL: assert property (@(posedge clk) disable iff (rst)
        (!grp_ready && !flush && !cmt_valid) |=> $stable(free_mask)); // R7
    AST_COMMIT_RETURNS_TAG: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && !flush) |=> free_mask[$past(cmt_tag)]); // R8
    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        flush |-> !grp_ready); // R10
    AST_FLUSH_FREES_ALL: assert property (@(posedge clk) disable iff (rst)
        flush |=> (&free_mask)); // R10
endmodule

bind rename_alias_table rat_rename_checker i_chk (.*);

// File: tb/test_rename_alias_table.sv
module test_rename_alias_table;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]      grp_valid = '0;
    logic [3:0][4:0] src_a_reg = '0;
    logic [3:0][4:0] src_b_reg = '0;
    logic [3:0]      dst_en = '0;
    logic [3:0][4:0] dst_reg = '0;
    logic            grp_ready;
    logic [3:0]      src_a_busy, src_b_busy;
    logic [3:0][4:0] src_a_tag, src_b_tag, dst_tag;
    logic            cmt_valid = 1'b0;
    logic [4:0]      cmt_reg = '0;
    logic [4:0]      cmt_tag = '0;
    logic            flush = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    rename_alias_table i_rename_alias_table (.*);

    int n_checks = 0;
    int n_err = 0;

    // Reference state built from the requirements
    bit mb[32];
    int mt[32];
    bit mfree[32];
    bit nd[4];
    int g[4];

    typedef struct packed {
        logic [3:0]      v;
        logic [3:0]      en;
        logic [3:0][4:0] d;
        logic [3:0][4:0] a;
        logic [3:0][4:0] b;
        logic            rdy;
    } vec_t;

    // Lane 3 is the leftmost element of each packed list
    localparam vec_t VECS [6] = '{
        '{4'b1111, 4'b1111, {5'd3, 5'd1, 5'd2, 5'd1}, {5'd1, 5'd2, 5'd1, 5'd5}, {5'd2, 5'd1, 5'd6, 5'd0}, 1'b1},
        '{4'b1111, 4'b0101, {5'd0, 5'd2, 5'd0, 5'd7}, {5'd7, 5'd3, 5'd2, 5'd1}, {5'd0, 5'd2, 5'd7, 5'd4}, 1'b1},
        '{4'b0101, 4'b1111, {5'd10, 5'd8, 5'd9, 5'd8}, {5'd8, 5'd8, 5'd3, 5'd8}, {5'd9, 5'd9, 5'd9, 5'd9}, 1'b1},
        '{4'b1111, 4'b1111, {5'd5, 5'd5, 5'd5, 5'd5}, {5'd5, 5'd5, 5'd5, 5'd5}, {5'd5, 5'd5, 5'd5, 5'd5}, 1'b1},
        '{4'b1111, 4'b0000, {5'd0, 5'd0, 5'd0, 5'd0}, {5'd5, 5'd3, 5'd2, 5'd1}, {5'd10, 5'd9, 5'd8, 5'd7}, 1'b1},
        '{4'b1000, 4'b1000, {5'd0, 5'd0, 5'd0, 5'd0}, {5'd0, 5'd0, 5'd0, 5'd0}, {5'd31, 5'd0, 5'd0, 5'd0}, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < 32; r++) begin
            mb[r] = 1'b0; mt[r] = 0; mfree[r] = 1'b1;
        end
    endtask

    // Expected lookup of one source in the current group
    task automatic exp_src(input int lane, input int r, output bit eb, output int et, output bit byp);
        eb = 1'b0; et = 0; byp = 1'b0;
        if (r != 0) begin
            eb = mb[r]; et = mt[r];
            for (int j = 0; j < lane; j++) begin
                if (nd[j] && dst_reg[j] == 5'(r)) begin
                    eb = 1'b1; et = g[j]; byp = 1'b1;
                end
            end
        end
    endtask

    task automatic step(input logic [3:0] v, input logic [3:0] en, input logic [3:0][4:0] d,
                        input logic [3:0][4:0] a, input logic [3:0][4:0] b,
                        input logic cv, input int cr, input int ct, input logic fl, input string req);
        int need_cnt;
        int free_cnt;
        bit rdy;
        bit avail[32];
        @(negedge clk);
        grp_valid = v; dst_en = en; dst_reg = d; src_a_reg = a; src_b_reg = b;
        cmt_valid = cv; cmt_reg = 5'(cr); cmt_tag = 5'(ct); flush = fl;
        #2;
        need_cnt = 0; free_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            nd[i] = v[i] && en[i] && (d[i] != 0);
            if (nd[i]) need_cnt++;
        end
        for (int t = 0; t < 32; t++) begin
            avail[t] = mfree[t];
            if (mfree[t]) free_cnt++;
        end
        rdy = !fl && (need_cnt <= free_cnt);
        chk(grp_ready === rdy, fl ? "R10" : "R7", {req, " ready"}, int'(grp_ready), int'(rdy));
        if (rdy) begin
            for (int i = 0; i < 4; i++) begin
                g[i] = 0;
                if (nd[i]) begin
                    for (int t = 31; t >= 0; t--) if (avail[t]) g[i] = t;
                    avail[g[i]] = 1'b0;
                    chk(dst_tag[i] == 5'(g[i]), "R4", $sformatf("%s lane%0d dst tag", req, i), int'(dst_tag[i]), g[i]);
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (v[i]) begin
                    bit eb; int et; bit byp;
                    exp_src(i, int'(a[i]), eb, et, byp);
                    chk(src_a_busy[i] === eb, byp ? "R3" : "R2", $sformatf("%s lane%0d srcA busy", req, i), int'(src_a_busy[i]), int'(eb));
                    if (eb) chk(src_a_tag[i] == 5'(et), byp ? "R3" : "R2", $sformatf("%s lane%0d srcA tag", req, i), int'(src_a_tag[i]), et);
                    exp_src(i, int'(b[i]), eb, et, byp);
                    chk(src_b_busy[i] === eb, byp ? "R3" : "R2", $sformatf("%s lane%0d srcB busy", req, i), int'(src_b_busy[i]), int'(eb));
                    if (eb) chk(src_b_tag[i] == 5'(et), byp ? "R3" : "R2", $sformatf("%s lane%0d srcB tag", req, i), int'(src_b_tag[i]), et);
                end
            end
        end
        @(posedge clk);
        #1;
        if (fl) begin
            model_clear();
        end else begin
            if (cv) begin
                if (mb[cr] && mt[cr] == ct) mb[cr] = 1'b0;
                mfree[ct] = 1'b1;
            end
            if (rdy) begin
                for (int i = 0; i < 4; i++) begin
                    if (nd[i]) begin
                        mb[d[i]] = 1'b1; mt[d[i]] = g[i]; mfree[g[i]] = 1'b0;
                    end
                end
            end
        end
    endtask

    // Lookup-only group reading registers base..base+7 through both ports
    task automatic look(input int base, input string req);
        logic [3:0][4:0] a, b;
        for (int i = 0; i < 4; i++) begin
            a[i] = 5'((base + i) % 32);
            b[i] = 5'((base + 4 + i) % 32);
        end
        step(4'b1111, 4'b0000, '0, a, b, 1'b0, 0, 0, 1'b0, req);
    endtask

    task automatic one_dst(input int r, input string req);
        step(4'b0001, 4'b0001, {15'd0, 5'(r)}, '0, '0, 1'b0, 0, 0, 1'b0, req);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ta, tb;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state, all registers read from the register file
        look(0, "R11");
        look(8, "R11");

        // R1: table of groups walked in order
        foreach (VECS[k]) begin
            step(VECS[k].v, VECS[k].en, VECS[k].d, VECS[k].a, VECS[k].b, 1'b0, 0, 0, 1'b0, "R1");
            chk(grp_ready === VECS[k].rdy, "R1", $sformatf("vector %0d ready", k), int'(grp_ready), int'(VECS[k].rdy));
        end
        look(0, "R1");
        look(8, "R1");

        // R5: two lanes write r20, youngest tag must remain
        step(4'b1111, 4'b0101, {5'd0, 5'd20, 5'd0, 5'd20}, {5'd20, 5'd20, 5'd20, 5'd20}, '0, 1'b0, 0, 0, 1'b0, "R5");
        look(17, "R5");

        // R6: destination register 0 takes no tag, next lane gets the lowest free one
        step(4'b0011, 4'b0011, {5'd0, 5'd0, 5'd21, 5'd0}, {5'd0, 5'd0, 5'd0, 5'd0}, '0, 1'b0, 0, 0, 1'b0, "R6");
        look(18, "R6");

        // R8: stale commit leaves the newer mapping alone
        one_dst(12, "R8"); ta = mt[12];
        one_dst(12, "R8"); tb = mt[12];
        step('0, '0, '0, '0, '0, 1'b1, 12, ta, 1'b0, "R8");
        look(12, "R8");
        step('0, '0, '0, '0, '0, 1'b1, 12, tb, 1'b0, "R8");
        look(12, "R8");

        // R9: commit and rename of the same register in one cycle
        one_dst(13, "R9"); ta = mt[13];
        step(4'b0001, 4'b0001, {15'd0, 5'd13}, '0, '0, 1'b1, 13, ta, 1'b0, "R9");
        look(10, "R9");

        // R10: flush with a commit in the same cycle
        step(4'b1111, 4'b1111, {5'd1, 5'd2, 5'd3, 5'd4}, '0, '0, 1'b1, 13, mt[13], 1'b1, "R10");
        look(0, "R10");
        look(24, "R10");

        // R7: exhaust all 32 tags, then stall
        for (int grp = 0; grp < 8; grp++) begin
            logic [3:0][4:0] dd;
            for (int i = 0; i < 4; i++) dd[i] = 5'(((4 * grp + i) % 31) + 1);
            step(4'b1111, 4'b1111, dd, '0, '0, 1'b0, 0, 0, 1'b0, "R7");
        end
        one_dst(9, "R7");
        look(6, "R7");
        step('0, '0, '0, '0, '0, 1'b1, 1, 0, 1'b0, "R8");
        step(4'b0011, 4'b0011, {10'd0, 5'd15, 5'd14}, '0, '0, 1'b0, 0, 0, 1'b0, "R7");
        one_dst(9, "R7");
        look(8, "R7");

        // R10: tags restart from the lowest after a flush
        step('0, '0, '0, '0, '0, 1'b0, 0, 0, 1'b1, "R10");
        step(4'b1111, 4'b1111, {5'd4, 5'd3, 5'd2, 5'd1}, {5'd3, 5'd2, 5'd1, 5'd0}, '0, 1'b0, 0, 0, 1'b0, "R10");

        finish_run();
    end
endmodule